// File: doc/BRIEF.md
# Incrementing Burst Slicer

This block sits on one initiator port of a multi-layer bus fabric and watches the beats that the port issues. When the initiator opens an incrementing burst of undefined length, the block marks the points where the downstream arbiter may take the target away and hand it to another initiator. It does this with a one-cycle early end-of-burst pulse. A programmable slice size sets those points. The slice can be every beat, every 4, 8 or 16 beats, or never. The arbiter itself, address decoding and data routing belong to other blocks.

A beat counts as accepted in a cycle where both `beat_valid` and `beat_ready` are high. The initiator marks the first beat of every burst with `burst_first`. On that same beat, `burst_undef` tells whether the burst has undefined length. The slice mode is latched from the mode register when a burst opens, so the slicing of a burst already under way never changes. Bursts of fixed length are never sliced. The running beat count is brought out so that neighbouring logic can see where the initiator stands within the current slice.

Top module: `incr_burst_slicer`

## Requirements
- R1: After a synchronous reset, the mode register holds 0, `beat_count` is 0 and no `slice_end` pulse is given until a sliced burst reaches a boundary.
- R2: Mode 0 never raises `slice_end` during an undefined-length burst. `beat_count` then rises by one per accepted beat and wraps at its width.
- R3: Mode 1 raises `slice_end` on every accepted beat of an undefined-length burst, and `beat_count` stays 0.
- R4: Mode 2 raises `slice_end` on the 4th, 8th, 12th and later multiples of 4 among the accepted beats of an undefined-length burst.
- R5: Mode 3 raises `slice_end` on every 8th accepted beat, and mode 4 on every 16th accepted beat, of an undefined-length burst.
- R6: Mode codes 5, 6 and 7 behave exactly like mode 0.
- R7: `beat_count` changes only on an accepted beat (valid and ready both 1). Stall and idle cycles leave it unchanged and give no `slice_end`.
- R8: An accepted beat with `burst_first`=1 is index 0 of a new burst, whatever the count was before. After it, `beat_count` reads 1, or 0 if that beat ended a slice.
- R9: `slice_end` is high in the same cycle as the accepted beat that closes a slice. In the next cycle `beat_count` reads 0.
- R10: A write to the mode register (`mode_we`=1 loads `mode_wdata` at the clock edge) affects only bursts whose first beat is accepted after the write. A burst already open keeps the mode latched at its first beat.
- R11: A burst whose first beat carries `burst_undef`=0 is never sliced, in any mode. Its beats still advance `beat_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the slice mode register |
| mode_wdata | input | 3 | Value loaded into the mode register |
| beat_valid | input | 1 | Initiator presents a beat |
| beat_ready | input | 1 | Fabric accepts the presented beat |
| burst_first | input | 1 | Beat is the first of a burst |
| burst_undef | input | 1 | Burst has undefined length (sampled with burst_first) |
| slice_end | output | 1 | Rearbitration allowed after this accepted beat |
| beat_count | output | CNT_W | Accepted beats so far in the current slice |

## Verification
A counter that drifts by one beat shows up at once. The next boundary pulse then moves off its multiple of the slice size, and `beat_count` reads a wrong value one cycle after the stray beat. A mode latched at the wrong moment shows differently: the slice after a mid-burst mode write ends at the new size rather than the old one. That error appears at the first boundary where the two sizes differ, within 16 beats. A stale undefined-length flag shows as pulses during a fixed-length burst on its first would-be boundary.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_UNBOUNDED = 3'd0,
    MODE_EACH_BEAT = 3'd1,
    MODE_SLICE4    = 3'd2,
    MODE_SLICE8    = 3'd3,
    MODE_SLICE16   = 3'd4
  } slice_mode_e;

  typedef struct packed {
    logic       cut;       // slicing enabled for this mode
    logic [3:0] last_idx;  // index of the closing beat within a slice
  } slice_cfg_t;

  // Reserved codes fall to the default arm: no slicing.
  function automatic slice_cfg_t decode_mode(input logic [MODE_W-1:0] m);
    slice_cfg_t c;
    c = '{cut: 1'b0, last_idx: 4'd0};
    case (m)
      MODE_EACH_BEAT: c = '{cut: 1'b1, last_idx: 4'd0};
      MODE_SLICE4:    c = '{cut: 1'b1, last_idx: 4'd3};
      MODE_SLICE8:    c = '{cut: 1'b1, last_idx: 4'd7};
      MODE_SLICE16:   c = '{cut: 1'b1, last_idx: 4'd15};
      default:        c = '{cut: 1'b0, last_idx: 4'd0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/slicer_mode_reg.sv
module slicer_mode_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst)     mode_q <= '0;
    else if (we) mode_q <= wdata;
  end

endmodule

// File: rtl/slicer_burst_track.sv
module slicer_burst_track
  import slicer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              first,
  input  logic              undef,
  input  logic [MODE_W-1:0] mode_now,
  output logic              cut_en,
  output logic [3:0]        last_idx
);

  logic              undef_q;
  logic [MODE_W-1:0] mode_lat;
  logic              eff_undef;
  logic [MODE_W-1:0] eff_mode;
  slice_cfg_t        cfg;

  // The burst opener uses the live register; later beats use the latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      undef_q  <= 1'b0;
      mode_lat <= '0;
    end else if (accept && first) begin
      undef_q  <= undef;
      mode_lat <= mode_now;
    end
  end

  always_comb begin
    eff_undef = first ? undef    : undef_q;
    eff_mode  = first ? mode_now : mode_lat;
    cfg       = decode_mode(eff_mode);
    cut_en    = eff_undef & cfg.cut;
    last_idx  = cfg.last_idx;
  end

endmodule

// File: rtl/slicer_beat_counter.sv
module slicer_beat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             first,
  input  logic             close,
  output logic [CNT_W-1:0] beat_idx,
  output logic [CNT_W-1:0] cnt_q
);

  always_comb beat_idx = first ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (accept) cnt_q <= close ? '0 : beat_idx + 1'b1;
  end

endmodule

// File: rtl/incr_burst_slicer.sv
module incr_burst_slicer
  import slicer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [2:0]       mode_wdata,
  input  logic             beat_valid,
  input  logic             beat_ready,
  input  logic             burst_first,
  input  logic             burst_undef,
  output logic             slice_end,
  output logic [CNT_W-1:0] beat_count
);

  localparam int IDX_W = 4;

  logic              accept;
  logic [MODE_W-1:0] mode_q;
  logic              cut_en;
  logic [IDX_W-1:0]  last_idx;
  logic [CNT_W-1:0]  beat_idx;
  logic              close;

  generate
    if (CNT_W < IDX_W) begin : g_bad_width
      initial $error("CNT_W must hold a 16-beat slice index");
    end
  endgenerate

  always_comb accept = beat_valid & beat_ready;

  slicer_mode_reg #(.W(MODE_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .we     (mode_we),
    .wdata  (mode_wdata),
    .mode_q (mode_q)
  );

  slicer_burst_track u_track (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .first    (burst_first),
    .undef    (burst_undef),
    .mode_now (mode_q),
    .cut_en   (cut_en),
    .last_idx (last_idx)
  );

  always_comb close = accept & cut_en & (beat_idx == CNT_W'(last_idx));

  slicer_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .first    (burst_first),
    .close    (close),
    .beat_idx (beat_idx),
    .cnt_q    (beat_count)
  );

  // Combinational so the pulse lines up with the closing beat itself.
  always_comb slice_end = close;

endmodule

// File: rtl/incr_burst_slicer_chk.sv
module incr_burst_slicer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic             burst_first,
  input logic             slice_end,
  input logic [CNT_W-1:0] beat_count
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> beat_count == '0);

  // R9
  pulse_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
    slice_end |-> (beat_valid && beat_ready));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(beat_valid && beat_ready) |=> $stable(beat_count));

  // R9
  restart_after_cut_chk: assert property (@(posedge clk) disable iff (rst)
    slice_end |=> beat_count == '0);

  // R8
  first_beat_one_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && burst_first && !slice_end) |=> beat_count == CNT_W'(1));

  // R5 (with R3, R4): a cut inside a burst lands only on a slice-size boundary
  boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
    (slice_end && !burst_first) |->
      (beat_count == CNT_W'(0) || beat_count == CNT_W'(3) ||
       beat_count == CNT_W'(7) || beat_count == CNT_W'(15)));

endmodule

bind incr_burst_slicer incr_burst_slicer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .beat_valid  (beat_valid),
  .beat_ready  (beat_ready),
  .burst_first (burst_first),
  .slice_end   (slice_end),
  .beat_count  (beat_count)
);

// File: tb/tb_incr_burst_slicer.sv
module tb_incr_burst_slicer;

  localparam int CNT_W = 8;
  localparam int ROW_W = 17;

  logic             clk = 1'b0;
  logic             rst;
  logic             mode_we;
  logic [2:0]       mode_wdata;
  logic             beat_valid;
  logic             beat_ready;
  logic             burst_first;
  logic             burst_undef;
  logic             slice_end;
  logic [CNT_W-1:0] beat_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  incr_burst_slicer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .burst_first(burst_first), .burst_undef(burst_undef),
    .slice_end(slice_end), .beat_count(beat_count)
  );

  // Row: {we, mode[2:0], valid, ready, first, undef, exp_end, exp_cnt[7:0]}
  localparam int NROWS = 45;
  localparam logic [ROW_W-1:0] ROWS [NROWS] = '{
    // R2 mode 0 undefined burst, 5 beats
    {1'b0,3'd0,4'b1111,1'b0,8'd1}, {1'b0,3'd0,4'b1100,1'b0,8'd2},
    {1'b0,3'd0,4'b1100,1'b0,8'd3}, {1'b0,3'd0,4'b1100,1'b0,8'd4},
    {1'b0,3'd0,4'b1100,1'b0,8'd5},
    // write mode 2 while idle: R7 count held
    {1'b1,3'd2,4'b0000,1'b0,8'd5},
    // R4 mode 2 with a stall and an idle cycle (R7)
    {1'b0,3'd0,4'b1111,1'b0,8'd1}, {1'b0,3'd0,4'b1100,1'b0,8'd2},
    {1'b0,3'd0,4'b1000,1'b0,8'd2}, {1'b0,3'd0,4'b0100,1'b0,8'd2},
    {1'b0,3'd0,4'b1100,1'b0,8'd3}, {1'b0,3'd0,4'b1100,1'b1,8'd0},
    {1'b0,3'd0,4'b1100,1'b0,8'd1}, {1'b0,3'd0,4'b1100,1'b0,8'd2},
    {1'b0,3'd0,4'b1100,1'b0,8'd3}, {1'b0,3'd0,4'b1100,1'b1,8'd0},
    {1'b0,3'd0,4'b1100,1'b0,8'd1}, {1'b0,3'd0,4'b1100,1'b0,8'd2},
    // R8 new burst mid-slice restarts at index 0
    {1'b0,3'd0,4'b1111,1'b0,8'd1},
    // R10 mode 1 written mid-burst: burst keeps 4-beat slices
    {1'b1,3'd1,4'b0000,1'b0,8'd1},
    {1'b0,3'd0,4'b1100,1'b0,8'd2}, {1'b0,3'd0,4'b1100,1'b0,8'd3},
    {1'b0,3'd0,4'b1100,1'b1,8'd0}, {1'b0,3'd0,4'b1100,1'b0,8'd1},
    // R3 mode 1 now active on a new undefined burst
    {1'b0,3'd0,4'b1111,1'b1,8'd0}, {1'b0,3'd0,4'b1100,1'b1,8'd0},
    {1'b0,3'd0,4'b1000,1'b0,8'd0}, {1'b0,3'd0,4'b1100,1'b1,8'd0},
    // R11 fixed-length burst in mode 1 is not sliced
    {1'b0,3'd0,4'b1110,1'b0,8'd1}, {1'b0,3'd0,4'b1100,1'b0,8'd2},
    {1'b0,3'd0,4'b1100,1'b0,8'd3}, {1'b0,3'd0,4'b1100,1'b0,8'd4},
    // R6 reserved mode 6
    {1'b1,3'd6,4'b0000,1'b0,8'd4},
    {1'b0,3'd0,4'b1111,1'b0,8'd1}, {1'b0,3'd0,4'b1100,1'b0,8'd2},
    {1'b0,3'd0,4'b1100,1'b0,8'd3}, {1'b0,3'd0,4'b1100,1'b0,8'd4},
    {1'b0,3'd0,4'b1100,1'b0,8'd5}, {1'b0,3'd0,4'b1100,1'b0,8'd6},
    // R11 fixed burst in mode 2
    {1'b1,3'd2,4'b0000,1'b0,8'd6},
    {1'b0,3'd0,4'b1110,1'b0,8'd1}, {1'b0,3'd0,4'b1100,1'b0,8'd2},
    {1'b0,3'd0,4'b1100,1'b0,8'd3}, {1'b0,3'd0,4'b1100,1'b0,8'd4},
    {1'b0,3'd0,4'b1100,1'b0,8'd5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle, check the pulse before the edge and the count after it.
  task automatic step(input bit we, input logic [2:0] m, input bit v, input bit r,
                      input bit f, input bit u, input bit e_end, input int e_cnt,
                      input string req);
    @(negedge clk);
    mode_we = we; mode_wdata = m;
    beat_valid = v; beat_ready = r; burst_first = f; burst_undef = u;
    #2;
    check(slice_end == e_end, {req, " slice_end"}, int'(slice_end), int'(e_end));
    @(posedge clk);
    #2;
    check(beat_count == CNT_W'(e_cnt), {req, " beat_count"}, int'(beat_count), e_cnt);
    mode_we = 1'b0;
  endtask

  task automatic write_mode(input logic [2:0] m);
    step(1'b1, m, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, int'(beat_count), "R10 write");
  endtask

  // Undefined burst of n beats with slice size sz (0 = never cut).
  task automatic run_burst(input int n, input int sz, input string req);
    for (int i = 0; i < n; i++) begin
      bit e;
      int c;
      e = (sz != 0) && ((i % sz) == sz - 1);
      c = (sz != 0) ? ((i + 1) % sz) : ((i + 1) % 256);
      step(1'b0, 3'd0, 1'b1, 1'b1, i == 0, 1'b1, e, c, req);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_we = 1'b0; mode_wdata = '0;
    beat_valid = 1'b0; beat_ready = 1'b0; burst_first = 1'b0; burst_undef = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(beat_count == '0, "R1 beat_count", int'(beat_count), 0);
    check(slice_end == 1'b0, "R1 slice_end", int'(slice_end), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NROWS; k++) begin
      logic [ROW_W-1:0] row;
      row = ROWS[k];
      step(row[16], row[15:13], row[12], row[11], row[10], row[9], row[8],
           int'(row[7:0]), $sformatf("table row %0d", k));
    end

    // R5 mode 3: two 8-beat slices plus one beat
    write_mode(3'd3);
    run_burst(17, 8, "R5 mode3");
    // R5 mode 4: two 16-beat slices plus two beats
    write_mode(3'd4);
    run_burst(34, 16, "R5 mode4");
    // R6 reserved modes 5 and 7
    write_mode(3'd5);
    run_burst(20, 0, "R6 mode5");
    write_mode(3'd7);
    run_burst(20, 0, "R6 mode7");
    // R2 mode 0 wraps the counter without a cut
    write_mode(3'd0);
    run_burst(260, 0, "R2 wrap");

    // R1 mid-run reset clears count and mode (mode 4 written first)
    write_mode(3'd4);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check(beat_count == '0, "R1 reset mid-run", int'(beat_count), 0);
    @(negedge clk);
    rst = 1'b0;
    run_burst(18, 0, "R1 mode back to 0");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule